// File: doc/BRIEF.md
# Event Timestamp Capture Latch

This block freezes the value of a free-running 64-bit time counter at the moment a timing event message crosses the port, and keeps that value frozen until software has collected it. Two independent capture slots exist, one fed by transmit event strobes and one fed by receive event strobes. Each slot has its own enable, its own valid flag, and its own low and high 32-bit halves of the stamp.

Receive strobes come with a classification produced by an upstream parser: message type, protocol version, UDP destination port, whether the frame was carried directly over Ethernet, and whether its Ethertype matched the timing protocol value 0x88F7. A filter decides whether the event qualifies. The filter uses a mode field, a 32-bit match word, and the enable and stamp flags of the Ethertype filter. A slot accepts one stamp and then locks. Every later event is dropped until the high half is read, which software signals with a one-cycle read strobe.

Top module: `evt_stamp_latch`

## Requirements
- R1: When a transmit strobe arrives with the transmit enable high and the transmit valid flag low, the next cycle shows the transmit valid flag high and {stamp_hi, stamp_lo} equal to the counter value present in the strobe cycle.
- R2: While a slot's valid flag is high and no high-half read is signalled, later events are dropped and both stamp halves stay unchanged.
- R3: A high-half read strobe clears that slot's valid flag in the next cycle. An event arriving in the same cycle as the read strobe is dropped.
- R4: With a slot's enable low, its events are ignored. Lowering the enable does not clear a capture that is already pending.
- R5: The transmit and receive slots are independent. A capture or release on one slot leaves the other slot's valid flag and stamp untouched.
- R6: Receive mode 0 (version-1 over UDP) stamps only events that meet all of these conditions: version equals 1, the frame is not layer-2, the UDP port equals match[31:16], and the message type equals match[3:0].
- R7: Receive mode 1 (version-2 events) stamps events whose version equals 2 and whose message type is 0 to 3. Such an event is accepted over UDP when the port equals match[31:16], or as a layer-2 frame when the Ethertype filter admits it.
- R8: A layer-2 event is admitted only when all three of these are high: the Ethertype filter enable, its stamp flag, and the Ethertype-hit input. If any one of them is low, the event is rejected.
- R9: Receive modes 2 and 3 are reserved and stamp nothing.
- R10: After synchronous reset, both valid flags are low and all stamp halves read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_cnt | input | 64 | Free-running time counter |
| tx_en | input | 1 | Transmit capture enable |
| tx_evt | input | 1 | Transmit event strobe |
| tx_rd_hi | input | 1 | Transmit high-half read strobe (releases lock) |
| rx_en | input | 1 | Receive capture enable |
| rx_mode | input | 2 | Receive filter mode: 0 v1 UDP, 1 v2 events, 2/3 reserved |
| rx_match | input | 32 | Match word: UDP port in 31:16, message type in 3:0 |
| etf_en | input | 1 | Ethertype filter enable |
| etf_stamp | input | 1 | Ethertype filter stamp flag |
| rx_evt | input | 1 | Receive event strobe |
| rx_msg_type | input | 4 | Message type of the received event |
| rx_ver | input | 4 | Protocol version of the received event |
| rx_udp_port | input | 16 | UDP destination port of the received event |
| rx_is_l2 | input | 1 | Event carried directly over Ethernet |
| rx_etype_hit | input | 1 | Ethertype equals 0x88F7 |
| rx_rd_hi | input | 1 | Receive high-half read strobe (releases lock) |
| tx_stamp_lo | output | 32 | Transmit stamp, low half |
| tx_stamp_hi | output | 32 | Transmit stamp, high half |
| tx_valid | output | 1 | Transmit stamp held |
| rx_stamp_lo | output | 32 | Receive stamp, low half |
| rx_stamp_hi | output | 32 | Receive stamp, high half |
| rx_valid | output | 1 | Receive stamp held |

## Verification
The hardest situation to reach from the ports is a collision inside the locked window. This covers an event arriving exactly when the release strobe fires, and a disable that arrives while a stamp is still pending. The stimulus creates both cases on purpose. It pairs an event strobe with the read strobe in one cycle, and it drops the enable between capture and release. The counter advances in both halves every cycle, so a stamp that is overwritten or taken one cycle late shows up as a mismatch. A behavioural model, comparing on every cycle, follows the acceptance rules across all four filter modes and all three layer-2 gating inputs.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
    localparam int STAMP_W = 64;
    localparam int MSG_W   = 4;
    localparam int VER_W   = 4;
    localparam int PORT_W  = 16;
    localparam int MATCH_W = 32;

    typedef enum logic [1:0] {
        FILT_V1_UDP = 2'd0,
        FILT_V2_EVT = 2'd1,
        FILT_RSV_A  = 2'd2,
        FILT_RSV_B  = 2'd3
    } rx_filt_e;

    typedef struct packed {
        logic [MSG_W-1:0]  msg_type;
        logic [VER_W-1:0]  ver;
        logic [PORT_W-1:0] udp_port;
        logic              is_l2;
        logic              etype_hit;
    } rx_class_t;

    // Event messages occupy the lowest four type codes.
    function automatic logic is_event_msg(input logic [MSG_W-1:0] t);
        return (t < MSG_W'(4));
    endfunction
endpackage

// File: rtl/evt_rx_filter.sv
module evt_rx_filter
    import evt_stamp_pkg::*;
(
    input  rx_class_t             cls,
    input  rx_filt_e              mode,
    input  logic [MATCH_W-1:0]    match_word,
    input  logic                  etf_en,
    input  logic                  etf_stamp,
    output logic                  hit
);
    localparam int PORT_LSB = MATCH_W - PORT_W;

    logic port_ok;
    logic l2_ok;

    always_comb begin
        port_ok = (cls.udp_port == match_word[MATCH_W-1:PORT_LSB]);
        l2_ok   = cls.etype_hit && etf_en && etf_stamp;
        unique case (mode)
            FILT_V1_UDP: hit = (cls.ver == VER_W'(1)) && !cls.is_l2 && port_ok
                             && (cls.msg_type == match_word[MSG_W-1:0]);
            FILT_V2_EVT: hit = (cls.ver == VER_W'(2)) && is_event_msg(cls.msg_type)
                             && (cls.is_l2 ? l2_ok : port_ok);
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_capture_slot.sv
module evt_capture_slot #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         evt,
    input  logic         unlock,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] stamp,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            stamp <= '0;
        end else if (unlock) begin
            valid <= 1'b0;
        end else if (!valid && en && evt) begin
            valid <= 1'b1;
            stamp <= cnt;
        end
    end
endmodule

// File: rtl/evt_stamp_latch.sv
module evt_stamp_latch
    import evt_stamp_pkg::*;
#(
    parameter int CNT_W = STAMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     time_cnt,
    input  logic                 tx_en,
    input  logic                 tx_evt,
    input  logic                 tx_rd_hi,
    input  logic                 rx_en,
    input  logic [1:0]           rx_mode,
    input  logic [MATCH_W-1:0]   rx_match,
    input  logic                 etf_en,
    input  logic                 etf_stamp,
    input  logic                 rx_evt,
    input  logic [MSG_W-1:0]     rx_msg_type,
    input  logic [VER_W-1:0]     rx_ver,
    input  logic [PORT_W-1:0]    rx_udp_port,
    input  logic                 rx_is_l2,
    input  logic                 rx_etype_hit,
    input  logic                 rx_rd_hi,
    output logic [CNT_W/2-1:0]   tx_stamp_lo,
    output logic [CNT_W/2-1:0]   tx_stamp_hi,
    output logic                 tx_valid,
    output logic [CNT_W/2-1:0]   rx_stamp_lo,
    output logic [CNT_W/2-1:0]   rx_stamp_hi,
    output logic                 rx_valid
);
    localparam int HALF = CNT_W / 2;

    rx_class_t        rx_cls;
    logic             rx_hit;
    logic [CNT_W-1:0] tx_stamp;
    logic [CNT_W-1:0] rx_stamp;

    assign rx_cls = '{msg_type: rx_msg_type, ver: rx_ver, udp_port: rx_udp_port,
                      is_l2: rx_is_l2, etype_hit: rx_etype_hit};

    evt_rx_filter u_filt (
        .cls        (rx_cls),
        .mode       (rx_filt_e'(rx_mode)),
        .match_word (rx_match),
        .etf_en     (etf_en),
        .etf_stamp  (etf_stamp),
        .hit        (rx_hit)
    );

    evt_capture_slot #(.W(CNT_W)) u_tx (
        .clk(clk), .rst(rst), .en(tx_en), .evt(tx_evt), .unlock(tx_rd_hi),
        .cnt(time_cnt), .stamp(tx_stamp), .valid(tx_valid)
    );

    evt_capture_slot #(.W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .evt(rx_evt && rx_hit), .unlock(rx_rd_hi),
        .cnt(time_cnt), .stamp(rx_stamp), .valid(rx_valid)
    );

    assign tx_stamp_lo = tx_stamp[HALF-1:0];
    assign tx_stamp_hi = tx_stamp[CNT_W-1:HALF];
    assign rx_stamp_lo = rx_stamp[HALF-1:0];
    assign rx_stamp_hi = rx_stamp[CNT_W-1:HALF];
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
    parameter int CNT_W = 64
) (
    input logic               clk,
    input logic               rst,
    input logic [CNT_W-1:0]   time_cnt,
    input logic               tx_en,
    input logic               tx_evt,
    input logic               tx_rd_hi,
    input logic               tx_valid,
    input logic [CNT_W/2-1:0] tx_stamp_lo,
    input logic [CNT_W/2-1:0] tx_stamp_hi,
    input logic               rx_en,
    input logic               rx_evt,
    input logic               rx_hit,
    input logic               rx_rd_hi,
    input logic [1:0]         rx_mode,
    input logic               rx_valid,
    input logic [CNT_W/2-1:0] rx_stamp_lo,
    input logic [CNT_W/2-1:0] rx_stamp_hi
);
    AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && tx_en && tx_evt && !tx_rd_hi) |=>
        (tx_valid && {tx_stamp_hi, tx_stamp_lo} == $past(time_cnt))); // R1
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && rx_en && rx_evt && rx_hit && !rx_rd_hi) |=>
        (rx_valid && {rx_stamp_hi, rx_stamp_lo} == $past(time_cnt))); // R1
    AST_TX_LOCK: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_rd_hi) |=>
        (tx_valid && $stable(tx_stamp_lo) && $stable(tx_stamp_hi))); // R2
    AST_RX_LOCK: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_rd_hi) |=>
        (rx_valid && $stable(rx_stamp_lo) && $stable(rx_stamp_hi))); // R2
    AST_TX_RELEASE: assert property (@(posedge clk) disable iff (rst)
        tx_rd_hi |=> !tx_valid); // R3
    AST_RX_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rx_rd_hi |=> !rx_valid); // R3
    AST_TX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && !tx_en) |=> !tx_valid); // R4
    AST_RX_RSV_MODE: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && rx_mode[1]) |=> !rx_valid); // R9
endmodule

bind evt_stamp_latch evt_stamp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .time_cnt(time_cnt),
    .tx_en(tx_en), .tx_evt(tx_evt), .tx_rd_hi(tx_rd_hi), .tx_valid(tx_valid),
    .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi),
    .rx_en(rx_en), .rx_evt(rx_evt), .rx_hit(rx_hit), .rx_rd_hi(rx_rd_hi),
    .rx_mode(rx_mode), .rx_valid(rx_valid),
    .rx_stamp_lo(rx_stamp_lo), .rx_stamp_hi(rx_stamp_hi)
);

// File: tb/tb_evt_stamp_latch.sv
module tb_evt_stamp_latch;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] TINC = 64'h0000_0001_0000_0013;
    localparam logic [15:0] EV_PORT = 16'd319;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_cnt = 64'h0000_00A0_0000_0005;
    logic        tx_en = 0, tx_evt = 0, tx_rd_hi = 0;
    logic        rx_en = 0, rx_evt = 0, rx_rd_hi = 0;
    logic [1:0]  rx_mode = 0;
    logic [31:0] rx_match = 0;
    logic        etf_en = 0, etf_stamp = 0;
    logic [3:0]  rx_msg_type = 0, rx_ver = 0;
    logic [15:0] rx_udp_port = 0;
    logic        rx_is_l2 = 0, rx_etype_hit = 0;
    logic [31:0] tx_stamp_lo, tx_stamp_hi, rx_stamp_lo, rx_stamp_hi;
    logic        tx_valid, rx_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_stamp_latch dut (
        .clk(clk), .rst(rst), .time_cnt(time_cnt),
        .tx_en(tx_en), .tx_evt(tx_evt), .tx_rd_hi(tx_rd_hi),
        .rx_en(rx_en), .rx_mode(rx_mode), .rx_match(rx_match),
        .etf_en(etf_en), .etf_stamp(etf_stamp), .rx_evt(rx_evt),
        .rx_msg_type(rx_msg_type), .rx_ver(rx_ver), .rx_udp_port(rx_udp_port),
        .rx_is_l2(rx_is_l2), .rx_etype_hit(rx_etype_hit), .rx_rd_hi(rx_rd_hi),
        .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi), .tx_valid(tx_valid),
        .rx_stamp_lo(rx_stamp_lo), .rx_stamp_hi(rx_stamp_hi), .rx_valid(rx_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Acceptance rule written from the requirements (R6 R7 R8 R9).
    function automatic bit ref_accept();
        if (rx_mode == 2'd0)
            return rx_ver == 4'd1 && !rx_is_l2 && rx_udp_port == rx_match[31:16]
                   && rx_msg_type == rx_match[3:0];
        if (rx_mode == 2'd1) begin
            if (rx_ver != 4'd2 || rx_msg_type > 4'd3) return 0;
            if (rx_is_l2) return rx_etype_hit && etf_en && etf_stamp;
            return rx_udp_port == rx_match[31:16];
        end
        return 0;
    endfunction

    // Reference model
    bit          m_txv = 0, m_rxv = 0;
    logic [63:0] m_txs = 0, m_rxs = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_txv <= 0; m_rxv <= 0; m_txs <= 0; m_rxs <= 0;
        end else begin
            if (tx_rd_hi) m_txv <= 0;
            else if (!m_txv && tx_en && tx_evt) begin m_txv <= 1; m_txs <= time_cnt; end
            if (rx_rd_hi) m_rxv <= 0;
            else if (!m_rxv && rx_en && rx_evt && ref_accept()) begin m_rxv <= 1; m_rxs <= time_cnt; end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("model R1 R2 R3 R4 tx_valid", {63'd0, tx_valid}, {63'd0, m_txv});
            chk("model R1 R2 R5 tx_stamp", {tx_stamp_hi, tx_stamp_lo}, m_txs);
            chk("model R6 R7 R8 R9 rx_valid", {63'd0, rx_valid}, {63'd0, m_rxv});
            chk("model R2 R5 rx_stamp", {rx_stamp_hi, rx_stamp_lo}, m_rxs);
        end
    end

    // One clock: inputs launched now are sampled at the coming edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        tx_evt = 0; rx_evt = 0; tx_rd_hi = 0; rx_rd_hi = 0;
        time_cnt = time_cnt + TINC;
    endtask

    task automatic rx_set(input logic [3:0] ver, input logic [3:0] mt,
                          input logic [15:0] port, input logic l2, input logic eh);
        rx_ver = ver; rx_msg_type = mt; rx_udp_port = port; rx_is_l2 = l2; rx_etype_hit = eh;
    endtask

    task automatic rx_try(input string req, input bit exp_hit);
        logic [63:0] t;
        t = time_cnt;
        rx_evt = 1;
        tick();
        chk(req, {63'd0, rx_valid}, {63'd0, exp_hit});
        if (exp_hit) chk(req, {rx_stamp_hi, rx_stamp_lo}, t);
        rx_rd_hi = 1;
        tick();
    endtask

    initial begin
        logic [63:0] t0, t1;
        tick(); tick();
        rst = 0;
        tick();
        // R10 reset state
        chk("R10 tx_valid", {63'd0, tx_valid}, 64'd0);
        chk("R10 rx_valid", {63'd0, rx_valid}, 64'd0);
        chk("R10 tx_stamp", {tx_stamp_hi, tx_stamp_lo}, 64'd0);
        chk("R10 rx_stamp", {rx_stamp_hi, rx_stamp_lo}, 64'd0);

        // R1 capture
        tx_en = 1; t0 = time_cnt; tx_evt = 1; tick();
        chk("R1 tx_valid", {63'd0, tx_valid}, 64'd1);
        chk("R1 tx_stamp", {tx_stamp_hi, tx_stamp_lo}, t0);
        // R2 lock
        tx_evt = 1; tick(); tick();
        chk("R2 tx_stamp held", {tx_stamp_hi, tx_stamp_lo}, t0);
        // R3 release, then collision of release and event
        tx_rd_hi = 1; tick();
        chk("R3 released", {63'd0, tx_valid}, 64'd0);
        tx_evt = 1; tick();
        chk("R1 recapture", {tx_stamp_hi, tx_stamp_lo}, time_cnt - TINC);
        tx_rd_hi = 1; tx_evt = 1; tick();
        chk("R3 collide dropped", {63'd0, tx_valid}, 64'd0);
        // R4 disabled, and disable with pending capture
        tx_en = 0; tx_evt = 1; tick();
        chk("R4 disabled ignored", {63'd0, tx_valid}, 64'd0);
        tx_en = 1; t1 = time_cnt; tx_evt = 1; tick();
        tx_en = 0; tick(); tick();
        chk("R4 pending kept", {63'd0, tx_valid}, 64'd1);
        chk("R4 pending stamp", {tx_stamp_hi, tx_stamp_lo}, t1);

        // R5 independence: tx pending, rx captures and releases
        rx_en = 1; rx_mode = 2'd1; rx_match = {EV_PORT, 16'h0001};
        rx_set(4'd2, 4'd0, EV_PORT, 0, 0);
        t0 = time_cnt; rx_evt = 1; tick();
        chk("R5 rx captured", {rx_stamp_hi, rx_stamp_lo}, t0);
        chk("R5 tx untouched", {tx_stamp_hi, tx_stamp_lo}, t1);
        rx_rd_hi = 1; tick();
        chk("R5 tx still valid", {63'd0, tx_valid}, 64'd1);
        chk("R5 rx released", {63'd0, rx_valid}, 64'd0);
        tx_rd_hi = 1; tick();

        // R6 version-1 UDP mode, match type 1
        rx_mode = 2'd0;
        rx_set(4'd1, 4'd1, EV_PORT, 0, 0);        rx_try("R6 v1 match", 1);
        rx_set(4'd1, 4'd0, EV_PORT, 0, 0);        rx_try("R6 wrong type", 0);
        rx_set(4'd1, 4'd1, 16'd320, 0, 0);        rx_try("R6 wrong port", 0);
        rx_set(4'd2, 4'd1, EV_PORT, 0, 0);        rx_try("R6 wrong version", 0);
        etf_en = 1; etf_stamp = 1;
        rx_set(4'd1, 4'd1, EV_PORT, 1, 1);        rx_try("R6 layer2 rejected", 0);

        // R7 version-2 event mode
        rx_mode = 2'd1;
        rx_set(4'd2, 4'd3, EV_PORT, 0, 0);        rx_try("R7 udp event", 1);
        rx_set(4'd2, 4'd8, EV_PORT, 0, 0);        rx_try("R7 general msg", 0);
        rx_set(4'd2, 4'd2, 16'd320, 0, 0);        rx_try("R7 wrong port", 0);
        rx_set(4'd2, 4'd1, 16'd0, 1, 1);          rx_try("R7 layer2 event", 1);

        // R8 layer-2 gating
        etf_stamp = 0; rx_try("R8 no stamp flag", 0);
        etf_stamp = 1; etf_en = 0; rx_try("R8 filter off", 0);
        etf_en = 1; rx_set(4'd2, 4'd1, 16'd0, 1, 0); rx_try("R8 no etype hit", 0);

        // R9 reserved modes
        rx_set(4'd2, 4'd0, EV_PORT, 0, 0);
        rx_mode = 2'd2; rx_try("R9 mode2", 0);
        rx_mode = 2'd3; rx_try("R9 mode3", 0);

        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule